// File: doc/BRIEF.md
# CAN Error Status Register

This block holds the error status word of a CAN controller. It keeps a 3-bit code that names the most recent bus error. It also raises three fault-confinement flags by comparing the current transmit and receive error counter values against fixed limits. The error detectors and the error counters sit outside the block. The block takes a strobe and a type for each detected error, a strobe for each transfer that completed cleanly, and the two counter values. It presents one 8-bit status word to the CPU, which the CPU can also write.

The error-code field clears itself after every clean transfer. Hardware never produces code 7, so that code is left to software. Firmware writes 7 into the field and later reads the field back. If the value has changed, hardware has recorded an error or a clean transfer since the write. The bus-off flag is sticky: it holds until an external recovery strobe clears it. The warning and passive flags follow the counters one cycle behind.

Top module: `can_err_status`

## Requirements
- R1: After reset, and while reset is held, the status word reads 0x00.
- R2: Bits 7 and 3 of the status word always read 0. Bits 6:4 hold the error code, bit 2 is bus-off, bit 1 is error-passive and bit 0 is error-warning.
- R3: An error strobe with a code from 1 to 6 (1 stuff, 2 form, 3 acknowledgment, 4 bit-recessive, 5 bit-dominant, 6 CRC) places that code in bits 6:4 on the next cycle.
- R4: A clean-transfer strobe with no legal error strobe in the same cycle sets bits 6:4 to 0 on the next cycle.
- R5: An error strobe that carries code 0 or 7 leaves bits 6:4 unchanged.
- R6: A CPU write with no hardware update in the same cycle loads wr_data[6:4] into bits 6:4. This includes the value 7.
- R7: A legal error strobe takes priority over a clean-transfer strobe and over a CPU write in the same cycle. A clean-transfer strobe takes priority over a CPU write in the same cycle.
- R8: CPU writes to bits 7, 3, 2, 1 and 0 have no effect.
- R9: Bit 0 is 1 one cycle after tec > 96 or rec > 96. It is 0 one cycle after both counters are at or below 96.
- R10: Bit 1 is 1 one cycle after tec > 127 or rec > 127. It is 0 one cycle after both counters are at or below 127.
- R11: Bit 2 is set one cycle after tec > 255. It stays set after tec falls again.
- R12: A bus-off recovery strobe clears bit 2 on the next cycle. The strobe wins over a set condition in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_valid | input | 1 | An error was detected this cycle |
| err_code | input | 3 | Type of the detected error (1 to 6) |
| xfer_ok | input | 1 | A frame was sent or received without error this cycle |
| tec | input | 9 | Current transmit error counter value |
| rec | input | 8 | Current receive error counter value |
| wr_en | input | 1 | CPU write strobe for the status word |
| wr_data | input | 8 | CPU write data |
| boff_clear | input | 1 | Bus-off recovery strobe |
| status | output | 8 | Status word read by the CPU |

## Verification
The bench builds the block with its default parameters: a 9-bit transmit counter, an 8-bit receive counter, and limits of 96, 127 and 255. With a 9-bit transmit counter the overflow value 256 can be driven, so the set path of the sticky bus-off flag can be exercised. The bench also drives each counter to exactly its limit and to one above it. It checks the field priorities with same-cycle collisions between error strobes, clean transfers and CPU writes. It checks the ignored-write cases by reading back the status word.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_STUFF = 3'd1,
        ERR_FORM  = 3'd2,
        ERR_ACK   = 3'd3,
        ERR_BIT1  = 3'd4,
        ERR_BIT0  = 3'd5,
        ERR_CRC   = 3'd6,
        ERR_SW    = 3'd7
    } err_code_e;

    typedef struct packed {
        logic [2:0] code;
    } lec_state_t;

    typedef struct packed {
        logic boff;
        logic passive;
        logic warn;
    } flag_state_t;

    function automatic logic code_is_hw(input logic [2:0] c);
        return (c != ERR_NONE) && (c != ERR_SW);
    endfunction

endpackage

// File: rtl/can_lec_track.sv
module can_lec_track
    import can_err_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_valid,
    input  logic [2:0] err_code,
    input  logic       xfer_ok,
    input  logic       wr_en,
    input  logic [2:0] wr_code,
    output logic [2:0] code
);

    lec_state_t st_d, st_q;
    logic       hw_err;

    always_comb begin
        hw_err = err_valid && code_is_hw(err_code);
        st_d   = st_q;
        if (hw_err) begin
            st_d.code = err_code;
        end else if (xfer_ok) begin
            st_d.code = ERR_NONE;
        end else if (wr_en) begin
            st_d.code = wr_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;

    AST_LEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && code_is_hw(err_code)) |=> (code == $past(err_code))); // R3
    AST_LEC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ok && !(err_valid && code_is_hw(err_code))) |=> (code == 3'd0)); // R4
    AST_LEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(err_valid && code_is_hw(err_code)) && !xfer_ok && !wr_en) |=> $stable(code)); // R5
    AST_LEC_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_valid && code_is_hw(err_code)) || xfer_ok) |=> (code != 3'd7)); // R7

endmodule

// File: rtl/can_fault_flags.sv
module can_fault_flags
    import can_err_pkg::*;
#(
    parameter int TEC_W         = 9,
    parameter int REC_W         = 8,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 127,
    parameter int BOFF_LIMIT    = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TEC_W-1:0] tec,
    input  logic [REC_W-1:0] rec,
    input  logic             boff_clear,
    output logic             boff,
    output logic             passive,
    output logic             warn
);

    localparam logic [TEC_W-1:0] TEC_WARN = TEC_W'(WARN_LIMIT);
    localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_LIMIT);
    localparam logic [TEC_W-1:0] TEC_BOFF = TEC_W'(BOFF_LIMIT);
    localparam logic [REC_W-1:0] REC_WARN = REC_W'(WARN_LIMIT);
    localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_LIMIT);

    flag_state_t st_d, st_q;
    logic        over_boff;

    always_comb begin
        over_boff  = tec > TEC_BOFF;
        st_d.warn    = (tec > TEC_WARN) || (rec > REC_WARN);
        st_d.passive = (tec > TEC_PASS) || (rec > REC_PASS);
        if (boff_clear) begin
            st_d.boff = 1'b0;
        end else begin
            st_d.boff = st_q.boff || over_boff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign boff    = st_q.boff;
    assign passive = st_q.passive;
    assign warn    = st_q.warn;

    AST_PASSIVE_HAS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        passive |-> warn); // R10
    AST_BOFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (boff && !boff_clear) |=> boff); // R11
    AST_BOFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        boff_clear |=> !boff); // R12
    AST_WARN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((tec <= TEC_WARN) && (rec <= REC_WARN)) |=> !warn); // R9

endmodule

// File: rtl/can_err_status.sv
module can_err_status
    import can_err_pkg::*;
#(
    parameter int TEC_W         = 9,
    parameter int REC_W         = 8,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 127,
    parameter int BOFF_LIMIT    = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_valid,
    input  logic [2:0]       err_code,
    input  logic             xfer_ok,
    input  logic [TEC_W-1:0] tec,
    input  logic [REC_W-1:0] rec,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             boff_clear,
    output logic [7:0]       status
);

    logic [2:0] code;
    logic       boff, passive, warn;

    can_lec_track u_lec (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_valid (err_valid),
        .err_code  (err_code),
        .xfer_ok   (xfer_ok),
        .wr_en     (wr_en),
        .wr_code   (wr_data[6:4]),
        .code      (code)
    );

    can_fault_flags #(
        .TEC_W         (TEC_W),
        .REC_W         (REC_W),
        .WARN_LIMIT    (WARN_LIMIT),
        .PASSIVE_LIMIT (PASSIVE_LIMIT),
        .BOFF_LIMIT    (BOFF_LIMIT)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .tec        (tec),
        .rec        (rec),
        .boff_clear (boff_clear),
        .boff       (boff),
        .passive    (passive),
        .warn       (warn)
    );

    assign status = {1'b0, code, 1'b0, boff, passive, warn};

    AST_FLAGS_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !boff_clear && !(tec > TEC_W'(BOFF_LIMIT)) && !boff) |=> !status[2]); // R8

endmodule

// File: tb/tb_can_err_status.sv
module tb_can_err_status;

    typedef struct packed {
        logic       ev;
        logic [2:0] ec;
        logic       ok;
        logic       we;
        logic [7:0] wd;
        logic [8:0] tec;
        logic [7:0] rec;
        logic       bc;
        logic [7:0] exp;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd0,   8'd0,   1'b0, 8'h00, 4'd1},  // R1 idle
        '{1'b1, 3'd1, 1'b0, 1'b0, 8'h00, 9'd0,   8'd0,   1'b0, 8'h10, 4'd3},  // R3 stuff
        '{1'b1, 3'd6, 1'b0, 1'b0, 8'h00, 9'd0,   8'd0,   1'b0, 8'h60, 4'd3},  // R3 crc
        '{1'b0, 3'd0, 1'b1, 1'b0, 8'h00, 9'd0,   8'd0,   1'b0, 8'h00, 4'd4},  // R4 clean
        '{1'b0, 3'd0, 1'b0, 1'b1, 8'h70, 9'd0,   8'd0,   1'b0, 8'h70, 4'd6},  // R6 sw 7
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd0,   8'd0,   1'b0, 8'h70, 4'd5},  // R5 hold
        '{1'b1, 3'd7, 1'b0, 1'b0, 8'h00, 9'd0,   8'd0,   1'b0, 8'h70, 4'd5},  // R5 code 7
        '{1'b1, 3'd0, 1'b0, 1'b0, 8'h00, 9'd0,   8'd0,   1'b0, 8'h70, 4'd5},  // R5 code 0
        '{1'b1, 3'd3, 1'b0, 1'b1, 8'h50, 9'd0,   8'd0,   1'b0, 8'h30, 4'd7},  // R7 err vs write
        '{1'b1, 3'd2, 1'b1, 1'b0, 8'h00, 9'd0,   8'd0,   1'b0, 8'h20, 4'd7},  // R7 err vs ok
        '{1'b0, 3'd0, 1'b1, 1'b1, 8'h70, 9'd0,   8'd0,   1'b0, 8'h00, 4'd7},  // R7 ok vs write
        '{1'b0, 3'd0, 1'b0, 1'b1, 8'hFF, 9'd0,   8'd0,   1'b0, 8'h70, 4'd8},  // R8 all ones
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd96,  8'd0,   1'b0, 8'h70, 4'd9},  // R9 at limit
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd97,  8'd0,   1'b0, 8'h71, 4'd9},  // R9 tec over
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd0,   8'd97,  1'b0, 8'h71, 4'd9},  // R9 rec over
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd0,   8'd127, 1'b0, 8'h71, 4'd10}, // R10 at limit
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd0,   8'd128, 1'b0, 8'h73, 4'd10}, // R10 rec over
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd128, 8'd0,   1'b0, 8'h73, 4'd10}, // R10 tec over
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd255, 8'd0,   1'b0, 8'h73, 4'd11}, // R11 at limit
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd256, 8'd0,   1'b0, 8'h77, 4'd11}, // R11 overflow
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd10,  8'd0,   1'b0, 8'h74, 4'd11}, // R11 sticky
        '{1'b0, 3'd0, 1'b0, 1'b1, 8'h07, 9'd10,  8'd0,   1'b0, 8'h04, 4'd8},  // R8 flag write
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd300, 8'd0,   1'b1, 8'h03, 4'd12}, // R12 clear wins
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd300, 8'd0,   1'b0, 8'h07, 4'd11}, // R11 set again
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 9'd0,   8'd0,   1'b1, 8'h00, 4'd12}  // R12 clear
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       err_valid = 1'b0;
    logic [2:0] err_code = 3'd0;
    logic       xfer_ok = 1'b0;
    logic [8:0] tec = 9'd0;
    logic [7:0] rec = 8'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       boff_clear = 1'b0;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    can_err_status dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_valid  (err_valid),
        .err_code   (err_code),
        .xfer_ok    (xfer_ok),
        .tec        (tec),
        .rec        (rec),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .boff_clear (boff_clear),
        .status     (status)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        err_valid  = v.ev;
        err_code   = v.ec;
        xfer_ok    = v.ok;
        wr_en      = v.we;
        wr_data    = v.wd;
        tec        = v.tec;
        rec        = v.rec;
        boff_clear = v.bc;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset held", status, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", status, 8'h00);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].rq, i), status, VEC[i].exp);
            check($sformatf("R2 reserved bits vector %0d", i), status & 8'h88, 8'h00);
        end

        // R11 / R9 / R10 / R3: load state, then reset mid-run (R1)
        apply('{1'b1, 3'd5, 1'b0, 1'b0, 8'h00, 9'd400, 8'd200, 1'b0, 8'h00, 4'd0});
        @(negedge clk);
        check("R3 bit-dominant with all flags", status, 8'h57);
        apply('0);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", status, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stays clear after reset", status, 8'h00);

        // R6: write 4 with flags idle, then R4 clean clears it
        wr_en = 1'b1; wr_data = 8'h40;
        @(negedge clk);
        check("R6 write code 4", status, 8'h40);
        wr_en = 1'b0; xfer_ok = 1'b1;
        @(negedge clk);
        check("R4 clean after write", status, 8'h00);
        xfer_ok = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule